// File: doc/BRIEF.md
# Keyed Clock-Gating Request Controller

This block decides, for five independent engine domains, whether each domain's clock should run. Software writes a request register with one bit per domain: 1 asks for the clock to run, 0 asks for it to stop. The block turns each bit into a clock-enable output and feeds it to a clock-gate cell outside the block. Each domain also has a configuration bit that picks how the enable moves. In direct gating the enable simply follows the request one cycle later. In handshake gating the block first asks the engine to go idle and waits for the engine to acknowledge before it stops the clock. When the clock is restarted, the enable rises before the idle request is withdrawn.

Writes to the request register carry a 4-bit key in bits [31:28]. One key value makes the write set-only and another makes it clear-only. This lets several software agents each turn their own domain on or off without a read-modify-write sequence. Any other key value gives an ordinary write.

Top module: `cg_gate_ctrl`

## Requirements
- R1: After a synchronous reset the request register reads 0x0000001F, the configuration register reads 0x00000000, every clock enable is 1 and no idle request is asserted.
- R2: A write to the request register (byte offset 0x4) with bits [31:28] = 0x5 sets each request bit whose matching data bit in [4:0] is 1, and leaves the others unchanged.
- R3: A write to the request register with bits [31:28] = 0x2 clears each request bit whose matching data bit in [4:0] is 1, and leaves the others unchanged.
- R4: A write to the request register with any other key loads bits [4:0] directly. A read of the request register returns the request bits in [4:0] and zero in every other bit, the key field included.
- R5: The configuration register (byte offset 0x0) holds one bit per domain in [4:0]. It is written plainly, whatever the key, and reads back with zeros above bit 4. Bit value 0 selects direct gating and 1 selects handshake gating.
- R6: In direct gating a domain's clock enable equals its request bit one cycle after the request register changes, and its idle request stays 0.
- R7: In handshake gating, clearing a request raises idle_req in the next cycle while the enable stays 1. The enable drops in the cycle after idle_ack is sampled high, and idle_req stays high while the clock is stopped.
- R8: In handshake gating, setting the request of a stopped domain raises the enable in the next cycle while idle_req is still high. idle_req drops one cycle after that.
- R9: In handshake gating, if the request is set again before idle_ack arrives, the domain goes back to running: idle_req drops and the enable never falls.
- R10: Each domain follows only its own request, configuration and acknowledge bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of the register: 0x0 configuration, 0x4 request |
| reg_wdata | input | 32 | Write data, with the key in [31:28] for request writes |
| reg_rdata | output | 32 | Read data for the register selected by reg_addr (combinational) |
| idle_ack | input | 5 | Per-domain acknowledge from the engine that it is idle |
| idle_req | output | 5 | Per-domain request for the engine to go idle |
| clk_en | output | 5 | Per-domain clock enable for the external gate cell |

## Verification
The bench looks first at the key decode. A design that treated the set key as a plain write would clear the domains whose data bits are 0. One that ignored the clear key would leave clocks running, and one that echoed the key on reads would return nonzero upper bits. In handshake mode the bench holds idle_ack low for several cycles after idle_req rises, so a design that drops the enable early shows up as a premature 0. It also withdraws a stop request before any acknowledge arrives, which catches a controller that parks the clock anyway or leaves idle_req high. Mixed configuration patterns check that direct and handshake domains move on their own schedules, and a reference model is compared every cycle.

// File: rtl/cg_ctrl_pkg.sv
package cg_ctrl_pkg;

    localparam int NUM_DOM   = 5;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int KEY_W     = 4;
    localparam int KEY_LSB   = DATA_W - KEY_W;

    localparam logic [KEY_W-1:0]  KEY_SET_ONLY = 4'h5;
    localparam logic [KEY_W-1:0]  KEY_CLR_ONLY = 4'h2;

    localparam logic [ADDR_W-1:0] OFS_MODE = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_REQ  = 4'h4;

    typedef enum logic [1:0] {
        WR_PLAIN,
        WR_SET,
        WR_CLEAR
    } wr_kind_e;

    typedef enum logic [1:0] {
        DOM_RUN,
        DOM_DRAIN,
        DOM_PARKED,
        DOM_WAKE
    } dom_state_e;

    function automatic wr_kind_e decode_key(input logic [KEY_W-1:0] key);
        if (key == KEY_SET_ONLY)      return WR_SET;
        else if (key == KEY_CLR_ONLY) return WR_CLEAR;
        else                          return WR_PLAIN;
    endfunction

endpackage

// File: rtl/cg_req_regs.sv
module cg_req_regs
    import cg_ctrl_pkg::*;
#(
    parameter int N_DOM  = NUM_DOM,
    parameter int D_W    = DATA_W,
    parameter int A_W    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [A_W-1:0]   addr,
    input  logic [D_W-1:0]   wdata,
    output logic [N_DOM-1:0] req_q,
    output logic [N_DOM-1:0] mode_q,
    output logic [D_W-1:0]   rdata
);

    localparam int K_LSB = D_W - KEY_W;

    wr_kind_e         kind;
    logic [N_DOM-1:0] bits;
    logic             req_hit;
    logic             mode_hit;

    assign kind     = decode_key(wdata[D_W-1:K_LSB]);
    assign bits     = wdata[N_DOM-1:0];
    assign req_hit  = wr && (addr == A_W'(OFS_REQ));
    assign mode_hit = wr && (addr == A_W'(OFS_MODE));

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '1;
            mode_q <= '0;
        end else begin
            if (req_hit) begin
                unique case (kind)
                    WR_SET:   req_q <= req_q | bits;
                    WR_CLEAR: req_q <= req_q & ~bits;
                    default:  req_q <= bits;
                endcase
            end
            if (mode_hit) mode_q <= bits;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_W'(OFS_REQ))       rdata[N_DOM-1:0] = req_q;
        else if (addr == A_W'(OFS_MODE)) rdata[N_DOM-1:0] = mode_q;
    end

    // R2
    set_only_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_hit && kind == WR_SET) |-> ((req_q & $past(req_q)) == $past(req_q)));

    // R3
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_hit && kind == WR_CLEAR) |-> ((req_q & ~$past(req_q)) == '0));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(req_hit) |-> $stable(req_q));

endmodule

// File: rtl/cg_domain_fsm.sv
module cg_domain_fsm
    import cg_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_on,
    input  logic mode_idle,
    input  logic ack,
    output logic clk_en,
    output logic idle_req
);

    dom_state_e st, nxt;

    always_comb begin
        nxt = st;
        if (!mode_idle) begin
            nxt = req_on ? DOM_RUN : DOM_PARKED;
        end else begin
            unique case (st)
                DOM_RUN:    if (!req_on) nxt = DOM_DRAIN;
                DOM_DRAIN:  if (req_on) nxt = DOM_RUN;
                            else if (ack) nxt = DOM_PARKED;
                DOM_PARKED: if (req_on) nxt = DOM_WAKE;
                DOM_WAKE:   nxt = req_on ? DOM_RUN : DOM_DRAIN;
                default:    nxt = DOM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= DOM_RUN;
        else     st <= nxt;
    end

    assign clk_en   = (st != DOM_PARKED);
    assign idle_req = mode_idle && (st != DOM_RUN);

    // R6
    direct_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(mode_idle) |-> (clk_en == $past(req_on)));

    // R7
    stop_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_idle) && $fell(clk_en)) |-> $past(ack));

    // R8
    release_after_en_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_idle && $past(mode_idle) && $fell(idle_req)) |-> (clk_en && $past(clk_en)));

endmodule

// File: rtl/cg_gate_ctrl.sv
module cg_gate_ctrl
    import cg_ctrl_pkg::*;
#(
    parameter int N_DOM = NUM_DOM,
    parameter int D_W   = DATA_W,
    parameter int A_W   = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [A_W-1:0]   reg_addr,
    input  logic [D_W-1:0]   reg_wdata,
    output logic [D_W-1:0]   reg_rdata,
    input  logic [N_DOM-1:0] idle_ack,
    output logic [N_DOM-1:0] idle_req,
    output logic [N_DOM-1:0] clk_en
);

    logic [N_DOM-1:0] req_q;
    logic [N_DOM-1:0] mode_q;

    cg_req_regs #(.N_DOM(N_DOM), .D_W(D_W), .A_W(A_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .req_q  (req_q),
        .mode_q (mode_q),
        .rdata  (reg_rdata)
    );

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        cg_domain_fsm u_fsm (
            .clk       (clk),
            .rst       (rst),
            .req_on    (req_q[d]),
            .mode_idle (mode_q[d]),
            .ack       (idle_ack[d]),
            .clk_en    (clk_en[d]),
            .idle_req  (idle_req[d])
        );
    end

endmodule

// File: tb/tb_cg_gate_ctrl.sv
`timescale 1ns/1ps
module tb_cg_gate_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h4;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  idle_ack = '0;
    logic [4:0]  idle_req;
    logic [4:0]  clk_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cg_gate_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .idle_ack(idle_ack), .idle_req(idle_req), .clk_en(clk_en)
    );

    // Behavioural reference: phase 0 running, 1 waiting for ack, 2 stopped, 3 restarting
    logic [4:0] m_req;
    logic [4:0] m_cfg;
    int         m_ph [5];

    always @(posedge clk) begin
        if (rst) begin
            m_req = 5'h1F;
            m_cfg = 5'h00;
            for (int i = 0; i < 5; i++) m_ph[i] = 0;
        end else begin
            for (int i = 0; i < 5; i++) begin
                if (!m_cfg[i])                   m_ph[i] = m_req[i] ? 0 : 2;
                else if (m_ph[i] == 0)           m_ph[i] = m_req[i] ? 0 : 1;
                else if (m_ph[i] == 1)           m_ph[i] = m_req[i] ? 0 : (idle_ack[i] ? 2 : 1);
                else if (m_ph[i] == 2)           m_ph[i] = m_req[i] ? 3 : 2;
                else                             m_ph[i] = m_req[i] ? 0 : 1;
            end
            if (reg_wr && reg_addr == 4'h4) begin
                if (reg_wdata[31:28] == 4'h5)      m_req = m_req | reg_wdata[4:0];
                else if (reg_wdata[31:28] == 4'h2) m_req = m_req & ~reg_wdata[4:0];
                else                               m_req = reg_wdata[4:0];
            end
            if (reg_wr && reg_addr == 4'h0) m_cfg = reg_wdata[4:0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 0; i < 5; i++) begin
                chk(m_cfg[i] ? "R7 R8 R9 model enable" : "R6 model enable",
                    32'(clk_en[i]), 32'(m_ph[i] != 2));
                chk(m_cfg[i] ? "R7 R8 R9 model idle_req" : "R6 model idle_req",
                    32'(idle_req[i]), 32'(m_cfg[i] && m_ph[i] != 0));
            end
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'h4; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
        reg_addr = 4'h4;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 req reset", 4'h4, 32'h1F);
        rd_chk("R1 cfg reset", 4'h0, 32'h00);
        chk("R1 enables", 32'(clk_en), 32'h1F);
        chk("R1 idle_req", 32'(idle_req), 32'h00);

        // R3 clear-only, R6 direct timing
        wr_reg(4'h4, 32'h2000_0001);
        rd_chk("R3 clear one bit", 4'h4, 32'h1E);
        chk("R6 enable not yet moved", 32'(clk_en), 32'h1F);
        @(negedge clk);
        chk("R6 enable follows", 32'(clk_en), 32'h1E);
        chk("R6 no idle_req direct", 32'(idle_req), 32'h00);
        wr_reg(4'h4, 32'h2000_0000);
        rd_chk("R3 zero bits ignored", 4'h4, 32'h1E);

        // R2 set-only
        wr_reg(4'h4, 32'h2000_0006);
        rd_chk("R3 clear two", 4'h4, 32'h18);
        wr_reg(4'h4, 32'h5000_0002);
        rd_chk("R2 set keeps others", 4'h4, 32'h1A);
        wr_reg(4'h4, 32'h5000_0000);
        rd_chk("R2 zero bits ignored", 4'h4, 32'h1A);
        @(negedge clk);
        chk("R6 enables match", 32'(clk_en), 32'h1A);

        // R4 plain writes and readback
        wr_reg(4'h4, 32'hAFFF_FFE5);
        rd_chk("R4 plain write", 4'h4, 32'h05);
        wr_reg(4'h4, 32'h0000_0013);
        rd_chk("R4 key zero plain", 4'h4, 32'h13);
        wr_reg(4'h4, 32'h0000_001F);

        // R5 configuration
        wr_reg(4'h0, 32'h5000_0015);
        rd_chk("R5 cfg plain under set key", 4'h0, 32'h15);
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_chk("R5 cfg all", 4'h0, 32'h1F);
        rd_chk("R4 req unchanged by cfg write", 4'h4, 32'h1F);
        @(negedge clk);

        // R7 handshake stop of domain 2
        wr_reg(4'h4, 32'h2000_0004);
        chk("R7 idle_req not yet", 32'(idle_req), 32'h00);
        @(negedge clk);
        chk("R7 idle_req raised", 32'(idle_req), 32'h04);
        chk("R7 enable held", 32'(clk_en), 32'h1F);
        repeat (3) @(negedge clk);
        chk("R7 enable held without ack", 32'(clk_en), 32'h1F);
        idle_ack = 5'h04;
        @(negedge clk);
        idle_ack = 5'h00;
        chk("R7 enable dropped after ack", 32'(clk_en), 32'h1B);
        chk("R7 idle_req kept while stopped", 32'(idle_req), 32'h04);
        @(negedge clk);

        // R8 restart
        wr_reg(4'h4, 32'h5000_0004);
        chk("R8 still stopped", 32'(clk_en), 32'h1B);
        @(negedge clk);
        chk("R8 enable first", 32'(clk_en), 32'h1F);
        chk("R8 idle_req still high", 32'(idle_req), 32'h04);
        @(negedge clk);
        chk("R8 idle_req released", 32'(idle_req), 32'h00);

        // R9 withdrawn stop request on domain 3
        wr_reg(4'h4, 32'h2000_0008);
        @(negedge clk);
        chk("R9 idle_req raised", 32'(idle_req), 32'h08);
        wr_reg(4'h4, 32'h5000_0008);
        chk("R9 enable held", 32'(clk_en), 32'h1F);
        @(negedge clk);
        chk("R9 back to running", 32'(idle_req), 32'h00);
        chk("R9 enable never fell", 32'(clk_en), 32'h1F);

        // R10 mixed domains
        wr_reg(4'h0, 32'h0000_000A);
        wr_reg(4'h4, 32'h2000_001F);
        @(negedge clk);
        chk("R10 mixed enables", 32'(clk_en), 32'h0A);
        chk("R10 mixed idle_req", 32'(idle_req), 32'h0A);
        idle_ack = 5'h02;
        @(negedge clk);
        idle_ack = 5'h00;
        chk("R10 only acked domain stops", 32'(clk_en), 32'h08);
        chk("R10 idle_req kept", 32'(idle_req), 32'h0A);
        wr_reg(4'h4, 32'h5000_0015);
        @(negedge clk);
        chk("R10 direct domains restart", 32'(clk_en), 32'h1D);
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule